// File: doc/BRIEF.md
# Device Error Signaling Controller

This block takes one error event at a time from the detection logic of a PCI Express function and works out what that event means for the function's error state. Each event carries a status vector that should name a single error, a flag for the correctable class, an advisory flag, an unsupported-request flag and the 16-bit ID of the requester involved. The controller first confirms that the event names exactly one supported error. It then picks the severity, sets the sticky device-level and per-error status bits, and asks a separate header-log block to record the error where that applies. Finally it decides from the mask, severity and reporting-enable inputs whether an error message goes upstream. When a message is due, it is presented for one cycle together with its severity code and the source ID.

A non-fatal uncorrectable error that carries the advisory flag is reported as a correctable message under the advisory status bit. When the log block answers a request with an overflow and a message went out for the event, the controller issues a second, internally generated correctable event for the header-log-overflow error. Input events are stalled until that second event has been processed.

Top module: `err_signal_ctrl`

## Requirements
- R1: The event status is ANDed with the supported set of its class. The correctable set is bits 0, 6, 7, 8 and 12 to 15. The uncorrectable set is bits 4, 5 and 12 to 25. If zero bits or more than one bit remain, `rejectPulse` is high for one cycle, one cycle after acceptance. A rejected event changes no status and produces no message and no log request. Unsupported bits alongside a single supported bit are dropped silently.
- R2: An uncorrectable error is fatal exactly when its bit is set in `uncSeverity`. With the default severity value 0x00462030, bits 4, 5, 13, 17, 18 and 22 are fatal and all other uncorrectable errors are non-fatal.
- R3: A correctable event sets `devStatus[0]`, and its bit in `corStatus`, even when that bit is set in `corMask`. With the unsupported-request flag it also sets `devStatus[3]`. All status bits are sticky until reset.
- R4: A correctable message is sent only when the error is unmasked in `corMask` and `cerEn` is set. An event carrying the unsupported-request flag additionally needs `urEn`.
- R5: An uncorrectable event sets `devStatus[2]` (fatal) or `devStatus[1]` (non-fatal), sets `devStatus[3]` when it carries the unsupported-request flag, and sets its `uncStatus` bit. If the bit is set in `uncMask`, there is no log request and no message.
- R6: An unmasked uncorrectable message needs `serrEn`, or else `ferEn` (fatal) or `nferEn` (non-fatal). An unsupported-request event is dropped when both `urEn` and `serrEn` are clear.
- R7: A non-fatal uncorrectable event with the advisory flag follows the correctable rules with status bit 13. Its uncorrectable bit is also set and it is logged only if unmasked in `uncMask`. If bit 13 is masked in `corMask`, the uncorrectable bit is left untouched, nothing is logged and no message is sent. A fatal event ignores the advisory flag.
- R8: Each logged error raises `logReq` for one cycle, one cycle after acceptance, with the one-hot error in `logStatus` and the source in `logSourceId`.
- R9: If `logOverflow` is high during a `logReq` cycle that also carries a message, a correctable event for bit 15 with the same source ID is processed in the next cycle. Its result appears two cycles after the first message. Without a message there is no follow-up.
- R10: A message is a one-cycle `msgValid` pulse, one cycle after acceptance, with `msgSeverity` 01 (correctable), 10 (non-fatal) or 11 (fatal) and the event's source ID.
- R11: `evtReady` is low during a `logReq` cycle and during the follow-up cycle.
- R12: After reset all status outputs, `msgValid`, `rejectPulse` and `logReq` are zero and `evtReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtValid | input | 1 | Event offered |
| evtReady | output | 1 | Event can be accepted |
| evtStatus | input | 32 | Error status vector of the event |
| evtCorr | input | 1 | Event is in the correctable class |
| evtAdvisory | input | 1 | Event may be reported as advisory |
| evtUnsupReq | input | 1 | Event is an unsupported request |
| evtSourceId | input | 16 | Requester ID of the event |
| corMask | input | 32 | Correctable error mask |
| uncMask | input | 32 | Uncorrectable error mask |
| uncSeverity | input | 32 | Uncorrectable severity, 1 = fatal |
| cerEn | input | 1 | Correctable reporting enable |
| nferEn | input | 1 | Non-fatal reporting enable |
| ferEn | input | 1 | Fatal reporting enable |
| urEn | input | 1 | Unsupported-request reporting enable |
| serrEn | input | 1 | System-error enable |
| msgValid | output | 1 | Error message pulse |
| msgSeverity | output | 2 | Message severity code |
| msgSourceId | output | 16 | Message source ID |
| rejectPulse | output | 1 | Invalid status pulse |
| logReq | output | 1 | Header log request |
| logStatus | output | 32 | One-hot error to log |
| logSourceId | output | 16 | Source ID to log |
| logOverflow | input | 1 | Log block full, valid during logReq |
| devStatus | output | 4 | Detected: [0] corr, [1] non-fatal, [2] fatal, [3] unsupported request |
| corStatus | output | 32 | Sticky correctable status |
| uncStatus | output | 32 | Sticky uncorrectable status |

## Verification
The assertions assume that `logOverflow` has meaning only in a `logReq` cycle. They also assume that the configuration inputs stay constant while an event is in flight. The stimulus keeps to this: configuration and `logOverflow` are changed only at a falling edge while the block is idle, and `logOverflow` goes back to zero once the follow-up has been observed. Events are presented only at a falling edge and held until `evtReady` has been seen high, so an offer never overlaps the stall that follows an overflow.

// File: rtl/err_signal_pkg.sv
package err_signal_pkg;
  localparam int unsigned STATUS_W = 32;
  localparam int unsigned SRC_W    = 16;

  localparam logic [31:0] COR_SUPPORTED_DEF = 32'h0000_F1C1;
  localparam logic [31:0] UNC_SUPPORTED_DEF = 32'h03FF_F030;
  localparam logic [31:0] UNC_SEVERITY_DEF  = 32'h0046_2030;
  localparam int unsigned ADV_BIT_DEF = 13;
  localparam int unsigned OVF_BIT_DEF = 15;

  typedef enum logic [1:0] {
    SEV_NONE     = 2'b00,
    SEV_COR      = 2'b01,
    SEV_NONFATAL = 2'b10,
    SEV_FATAL    = 2'b11
  } msgSev_t;

  typedef enum logic {
    CTL_IDLE   = 1'b0,
    CTL_FOLLOW = 1'b1
  } ctlState_t;

  typedef struct packed {
    logic takeExt;
    logic takeOvf;
  } dpStrobe_t;
endpackage

// File: rtl/err_signal_datapath.sv
module err_signal_datapath
  import err_signal_pkg::*;
#(
  parameter int unsigned STW = 32,
  parameter int unsigned SW = 16,
  parameter logic [STW-1:0] COR_SUPPORTED = COR_SUPPORTED_DEF,
  parameter logic [STW-1:0] UNC_SUPPORTED = UNC_SUPPORTED_DEF,
  parameter int unsigned ADV_BIT = ADV_BIT_DEF,
  parameter int unsigned OVF_BIT = OVF_BIT_DEF
) (
  input  logic           clk,
  input  logic           rstN,
  input  dpStrobe_t      strobe,
  input  logic [STW-1:0] evtStatus,
  input  logic           evtCorr,
  input  logic           evtAdvisory,
  input  logic           evtUnsupReq,
  input  logic [SW-1:0]  evtSourceId,
  input  logic [STW-1:0] corMask,
  input  logic [STW-1:0] uncMask,
  input  logic [STW-1:0] uncSeverity,
  input  logic           cerEn,
  input  logic           nferEn,
  input  logic           ferEn,
  input  logic           urEn,
  input  logic           serrEn,
  output logic           msgValidQ,
  output logic [1:0]     msgSevQ,
  output logic [SW-1:0]  msgSrcQ,
  output logic           rejectQ,
  output logic           logReqQ,
  output logic [STW-1:0] logStatusQ,
  output logic [SW-1:0]  logSrcQ,
  output logic [3:0]     devStatusQ,
  output logic [STW-1:0] corStatusQ,
  output logic [STW-1:0] uncStatusQ
);
  localparam logic [STW-1:0] ADV_MASK = STW'(1) << ADV_BIT;
  localparam logic [STW-1:0] OVF_MASK = STW'(1) << OVF_BIT;

  logic [SW-1:0]  heldSrc;
  logic           take;
  logic [STW-1:0] curStatus;
  logic           curCorr, curAdv, curUr;
  logic [SW-1:0]  curSrc;
  logic [STW-1:0] keep, corBit;
  logic           oneHot, isFatal, advPath, corPath, corMasked, uncMasked;
  logic           sendMsg, doLog, rej;
  msgSev_t        sev;
  logic [3:0]     nDev;
  logic [STW-1:0] nCor, nUnc;

  // Event source: external input or the internal overflow follow-up
  always_comb begin
    take = strobe.takeExt | strobe.takeOvf;
    if (strobe.takeOvf) begin
      curStatus = OVF_MASK;
      curCorr   = 1'b1;
      curAdv    = 1'b0;
      curUr     = 1'b0;
      curSrc    = heldSrc;
    end else begin
      curStatus = evtStatus;
      curCorr   = evtCorr;
      curAdv    = evtAdvisory;
      curUr     = evtUnsupReq;
      curSrc    = evtSourceId;
    end
  end

  // Classification
  always_comb begin
    keep      = curStatus & (curCorr ? COR_SUPPORTED : UNC_SUPPORTED);
    oneHot    = (keep != '0) && ((keep & (keep - STW'(1))) == '0);
    isFatal   = !curCorr && (|(keep & uncSeverity));
    advPath   = !curCorr && !isFatal && curAdv;
    corPath   = curCorr || advPath;
    corBit    = curCorr ? keep : ADV_MASK;
    corMasked = |(corBit & corMask);
    uncMasked = |(keep & uncMask);
  end

  // Status update and message decision
  always_comb begin
    nDev    = devStatusQ;
    nCor    = corStatusQ;
    nUnc    = uncStatusQ;
    sendMsg = 1'b0;
    doLog   = 1'b0;
    rej     = 1'b0;
    sev     = SEV_NONE;
    if (take) begin
      if (!oneHot) begin
        rej = 1'b1;
      end else if (corPath) begin
        nDev[0] = 1'b1;
        if (curUr) nDev[3] = 1'b1;
        nCor = corStatusQ | corBit;
        sev  = SEV_COR;
        if (!corMasked) begin
          if (advPath) begin
            doLog = !uncMasked;
            nUnc  = uncStatusQ | keep;
          end
          sendMsg = cerEn && !(curUr && !urEn);
        end
      end else begin
        if (isFatal) nDev[2] = 1'b1;
        else         nDev[1] = 1'b1;
        if (curUr) nDev[3] = 1'b1;
        nUnc = uncStatusQ | keep;
        sev  = isFatal ? SEV_FATAL : SEV_NONFATAL;
        if (!uncMasked) begin
          doLog   = 1'b1;
          sendMsg = !(curUr && !urEn && !serrEn) &&
                    (serrEn || (isFatal ? ferEn : nferEn));
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldSrc    <= '0;
      msgValidQ  <= 1'b0;
      msgSevQ    <= SEV_NONE;
      msgSrcQ    <= '0;
      rejectQ    <= 1'b0;
      logReqQ    <= 1'b0;
      logStatusQ <= '0;
      logSrcQ    <= '0;
      devStatusQ <= '0;
      corStatusQ <= '0;
      uncStatusQ <= '0;
    end else begin
      if (strobe.takeExt) heldSrc <= evtSourceId;
      msgValidQ  <= sendMsg;
      rejectQ    <= rej;
      logReqQ    <= doLog;
      devStatusQ <= nDev;
      corStatusQ <= nCor;
      uncStatusQ <= nUnc;
      if (sendMsg) begin
        msgSevQ <= sev;
        msgSrcQ <= curSrc;
      end
      if (doLog) begin
        logStatusQ <= keep;
        logSrcQ    <= curSrc;
      end
    end
  end
endmodule

// File: rtl/err_signal_control.sv
module err_signal_control
  import err_signal_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      evtValid,
  input  logic      logReqQ,
  input  logic      msgValidQ,
  input  logic      logOverflow,
  output logic      evtReady,
  output dpStrobe_t strobe
);
  ctlState_t state, stateNext;

  always_comb begin
    evtReady       = (state == CTL_IDLE) && !logReqQ;
    strobe.takeExt = evtValid && evtReady;
    strobe.takeOvf = (state == CTL_FOLLOW);
    stateNext      = CTL_IDLE;
    if (state == CTL_IDLE && logReqQ && logOverflow && msgValidQ)
      stateNext = CTL_FOLLOW;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= CTL_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/err_signal_ctrl.sv
module err_signal_ctrl
  import err_signal_pkg::*;
#(
  parameter int unsigned STATUS_W = err_signal_pkg::STATUS_W,
  parameter int unsigned SRC_W = err_signal_pkg::SRC_W,
  parameter logic [STATUS_W-1:0] COR_SUPPORTED = COR_SUPPORTED_DEF,
  parameter logic [STATUS_W-1:0] UNC_SUPPORTED = UNC_SUPPORTED_DEF,
  parameter int unsigned ADV_BIT = ADV_BIT_DEF,
  parameter int unsigned OVF_BIT = OVF_BIT_DEF
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                evtValid,
  output logic                evtReady,
  input  logic [STATUS_W-1:0] evtStatus,
  input  logic                evtCorr,
  input  logic                evtAdvisory,
  input  logic                evtUnsupReq,
  input  logic [SRC_W-1:0]    evtSourceId,
  input  logic [STATUS_W-1:0] corMask,
  input  logic [STATUS_W-1:0] uncMask,
  input  logic [STATUS_W-1:0] uncSeverity,
  input  logic                cerEn,
  input  logic                nferEn,
  input  logic                ferEn,
  input  logic                urEn,
  input  logic                serrEn,
  output logic                msgValid,
  output logic [1:0]          msgSeverity,
  output logic [SRC_W-1:0]    msgSourceId,
  output logic                rejectPulse,
  output logic                logReq,
  output logic [STATUS_W-1:0] logStatus,
  output logic [SRC_W-1:0]    logSourceId,
  input  logic                logOverflow,
  output logic [3:0]          devStatus,
  output logic [STATUS_W-1:0] corStatus,
  output logic [STATUS_W-1:0] uncStatus
);
  dpStrobe_t strobe;

  err_signal_control u_ctl (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .logReqQ(logReq),
    .msgValidQ(msgValid), .logOverflow(logOverflow),
    .evtReady(evtReady), .strobe(strobe)
  );

  err_signal_datapath #(
    .STW(STATUS_W), .SW(SRC_W), .COR_SUPPORTED(COR_SUPPORTED),
    .UNC_SUPPORTED(UNC_SUPPORTED), .ADV_BIT(ADV_BIT), .OVF_BIT(OVF_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .evtStatus(evtStatus), .evtCorr(evtCorr), .evtAdvisory(evtAdvisory),
    .evtUnsupReq(evtUnsupReq), .evtSourceId(evtSourceId),
    .corMask(corMask), .uncMask(uncMask), .uncSeverity(uncSeverity),
    .cerEn(cerEn), .nferEn(nferEn), .ferEn(ferEn), .urEn(urEn), .serrEn(serrEn),
    .msgValidQ(msgValid), .msgSevQ(msgSeverity), .msgSrcQ(msgSourceId),
    .rejectQ(rejectPulse), .logReqQ(logReq), .logStatusQ(logStatus),
    .logSrcQ(logSourceId), .devStatusQ(devStatus),
    .corStatusQ(corStatus), .uncStatusQ(uncStatus)
  );
endmodule

// File: rtl/err_signal_checker.sv
module err_signal_checker #(
  parameter int unsigned STATUS_W = 32,
  parameter int unsigned OVF_BIT = 15
) (
  input logic                clk,
  input logic                rstN,
  input logic                evtReady,
  input logic                msgValid,
  input logic [1:0]          msgSeverity,
  input logic                rejectPulse,
  input logic                logReq,
  input logic [STATUS_W-1:0] logStatus,
  input logic                logOverflow,
  input logic [3:0]          devStatus,
  input logic [STATUS_W-1:0] corStatus,
  input logic [STATUS_W-1:0] uncStatus
);
  // R10
  msg_reject_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(msgValid && rejectPulse));

  // R10
  msg_sev_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> (msgSeverity != 2'b00));

  // R11
  stall_on_log_chk: assert property (@(posedge clk) disable iff (!rstN)
    logReq |-> !evtReady);

  // R8
  log_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    logReq |-> ($countones(logStatus) == 1));

  // R1
  reject_keeps_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    rejectPulse |-> ($stable(corStatus) && $stable(uncStatus) && $stable(devStatus) && !logReq));

  // R3
  cor_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((corStatus & $past(corStatus)) == $past(corStatus)));

  // R5
  unc_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((uncStatus & $past(uncStatus)) == $past(uncStatus)));

  // R9
  ovf_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (logReq && logOverflow && msgValid) |=> ##1 corStatus[OVF_BIT]);
endmodule

bind err_signal_ctrl err_signal_checker #(.STATUS_W(STATUS_W), .OVF_BIT(OVF_BIT)) u_chk (
  .clk(clk), .rstN(rstN), .evtReady(evtReady), .msgValid(msgValid),
  .msgSeverity(msgSeverity), .rejectPulse(rejectPulse), .logReq(logReq),
  .logStatus(logStatus), .logOverflow(logOverflow), .devStatus(devStatus),
  .corStatus(corStatus), .uncStatus(uncStatus)
);

// File: tb/err_signal_ctrl_test.sv
`timescale 1ns/1ps
module err_signal_ctrl_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evtValid = 1'b0;
  logic evtReady;
  logic [31:0] evtStatus = '0;
  logic evtCorr = 1'b0, evtAdvisory = 1'b0, evtUnsupReq = 1'b0;
  logic [15:0] evtSourceId = '0;
  logic [31:0] corMask = '0, uncMask = '0, uncSeverity = 32'h0046_2030;
  logic cerEn = 1'b1, nferEn = 1'b1, ferEn = 1'b1, urEn = 1'b1, serrEn = 1'b1;
  logic msgValid, rejectPulse, logReq;
  logic [1:0] msgSeverity;
  logic [15:0] msgSourceId, logSourceId;
  logic [31:0] logStatus, corStatus, uncStatus;
  logic logOverflow = 1'b0;
  logic [3:0] devStatus;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic gotMsg, gotRej, gotLog, gotReady;
  logic [1:0] gotSev;
  logic [15:0] gotSrc;
  logic [31:0] gotLogSt;

  always #4 clk = ~clk;

  err_signal_ctrl uut (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtReady(evtReady),
    .evtStatus(evtStatus), .evtCorr(evtCorr), .evtAdvisory(evtAdvisory),
    .evtUnsupReq(evtUnsupReq), .evtSourceId(evtSourceId),
    .corMask(corMask), .uncMask(uncMask), .uncSeverity(uncSeverity),
    .cerEn(cerEn), .nferEn(nferEn), .ferEn(ferEn), .urEn(urEn), .serrEn(serrEn),
    .msgValid(msgValid), .msgSeverity(msgSeverity), .msgSourceId(msgSourceId),
    .rejectPulse(rejectPulse), .logReq(logReq), .logStatus(logStatus),
    .logSourceId(logSourceId), .logOverflow(logOverflow),
    .devStatus(devStatus), .corStatus(corStatus), .uncStatus(uncStatus)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    corMask = '0; uncMask = '0; uncSeverity = 32'h0046_2030;
    cerEn = 1; nferEn = 1; ferEn = 1; urEn = 1; serrEn = 1; logOverflow = 0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // Offer one event, return with outputs of the cycle after acceptance captured
  task automatic sendEvt(input logic [31:0] st, input logic corr, input logic adv,
                         input logic ur, input logic [15:0] src);
    @(negedge clk);
    evtStatus = st; evtCorr = corr; evtAdvisory = adv; evtUnsupReq = ur;
    evtSourceId = src; evtValid = 1'b1;
    while (!evtReady) @(negedge clk);
    @(negedge clk);
    evtValid = 1'b0;
    gotMsg = msgValid; gotSev = msgSeverity; gotSrc = msgSourceId;
    gotRej = rejectPulse; gotLog = logReq; gotLogSt = logStatus; gotReady = evtReady;
  endtask

  task automatic testReset();
    doReset();
    @(negedge clk);
    chk("R12 devStatus", 32'(devStatus), 0);
    chk("R12 corStatus", corStatus, 0);
    chk("R12 uncStatus", uncStatus, 0);
    chk("R12 msg/rej/log", {29'd0, msgValid, rejectPulse, logReq}, 0);
    chk("R12 ready", 32'(evtReady), 1);
  endtask

  task automatic testReject();
    doReset();
    sendEvt(32'h0000_0002, 0, 0, 0, 16'h0001);
    chk("R1 zero after mask reject", 32'(gotRej), 1);
    chk("R1 zero no msg", 32'(gotMsg), 0);
    chk("R1 zero no status", uncStatus, 0);
    sendEvt(32'h0000_0041, 1, 0, 0, 16'h0002);
    chk("R1 multi reject", 32'(gotRej), 1);
    chk("R1 multi no status", corStatus, 0);
    chk("R1 multi no dev", 32'(devStatus), 0);
    sendEvt(32'h8000_0001, 1, 0, 0, 16'h0003);
    chk("R1 extra unsupported bit dropped", 32'(gotRej), 0);
    chk("R1 masked to bit0", corStatus, 32'h1);
  endtask

  task automatic testCorrectable();
    doReset();
    sendEvt(32'h0000_0040, 1, 0, 0, 16'h1234);
    chk("R10 cor msg", 32'(gotMsg), 1);
    chk("R4 cor sev", 32'(gotSev), 1);
    chk("R10 src", 32'(gotSrc), 32'h1234);
    chk("R3 corStatus", corStatus, 32'h40);
    chk("R3 devStatus", 32'(devStatus), 1);
    @(negedge clk);
    chk("R10 single pulse", 32'(msgValid), 0);
    corMask = 32'h80;
    sendEvt(32'h0000_0080, 1, 0, 0, 16'h0010);
    chk("R4 masked no msg", 32'(gotMsg), 0);
    chk("R3 masked still sets", corStatus, 32'hC0);
    corMask = 0; cerEn = 0;
    sendEvt(32'h0000_0100, 1, 0, 0, 16'h0011);
    chk("R4 cerEn off no msg", 32'(gotMsg), 0);
    cerEn = 1; urEn = 0;
    sendEvt(32'h0000_0001, 1, 0, 1, 16'h0012);
    chk("R4 ur needs urEn", 32'(gotMsg), 0);
    chk("R3 ur dev bit", 32'(devStatus), 32'h9);
  endtask

  task automatic testUncorrectable();
    doReset();
    sendEvt(32'h0004_0000, 0, 0, 0, 16'hABCD);
    chk("R2 default fatal dev", 32'(devStatus), 32'h4);
    chk("R6 fatal sev", 32'(gotSev), 3);
    chk("R8 log req", 32'(gotLog), 1);
    chk("R8 log status", gotLogSt, 32'h0004_0000);
    chk("R8 log src", 32'(logSourceId), 32'hABCD);
    sendEvt(32'h0000_1000, 0, 0, 0, 16'h0020);
    chk("R2 default nonfatal sev", 32'(gotSev), 2);
    chk("R5 nonfatal dev", 32'(devStatus), 32'h6);
    uncSeverity = 32'h0046_3030;
    sendEvt(32'h0000_1000, 0, 0, 0, 16'h0021);
    chk("R2 severity override", 32'(gotSev), 3);
    uncSeverity = 32'h0046_2030; uncMask = 32'h4000;
    sendEvt(32'h0000_4000, 0, 0, 0, 16'h0022);
    chk("R5 masked status set", uncStatus & 32'h4000, 32'h4000);
    chk("R5 masked no log", 32'(gotLog), 0);
    chk("R5 masked no msg", 32'(gotMsg), 0);
    uncMask = 0; serrEn = 0; nferEn = 0;
    sendEvt(32'h0000_8000, 0, 0, 0, 16'h0023);
    chk("R6 no enable no msg", 32'(gotMsg), 0);
    chk("R8 logged anyway", 32'(gotLog), 1);
    serrEn = 1;
    sendEvt(32'h0001_0000, 0, 0, 0, 16'h0024);
    chk("R6 serr alone sends", 32'(gotMsg), 1);
  endtask

  task automatic testUnsupported();
    doReset();
    urEn = 0; serrEn = 0; nferEn = 1;
    sendEvt(32'h0010_0000, 0, 0, 1, 16'h0030);
    chk("R6 ur blocked", 32'(gotMsg), 0);
    chk("R5 ur dev bits", 32'(devStatus), 32'hA);
    urEn = 1;
    sendEvt(32'h0010_0000, 0, 0, 1, 16'h0031);
    chk("R6 ur with urEn", 32'(gotMsg), 1);
    chk("R6 ur sev", 32'(gotSev), 2);
  endtask

  task automatic testAdvisory();
    doReset();
    sendEvt(32'h0000_1000, 0, 1, 0, 16'h0040);
    chk("R7 adv cor sev", 32'(gotSev), 1);
    chk("R7 adv cor bit", corStatus, 32'h2000);
    chk("R7 adv unc bit", uncStatus, 32'h1000);
    chk("R7 adv logged", 32'(gotLog), 1);
    doReset();
    uncMask = 32'h1000;
    sendEvt(32'h0000_1000, 0, 1, 0, 16'h0041);
    chk("R7 adv unc masked no log", 32'(gotLog), 0);
    chk("R7 adv unc masked msg", 32'(gotMsg), 1);
    chk("R7 adv unc masked status", uncStatus, 32'h1000);
    doReset();
    corMask = 32'h2000;
    sendEvt(32'h0000_1000, 0, 1, 0, 16'h0042);
    chk("R7 adv cor masked no msg", 32'(gotMsg), 0);
    chk("R7 adv cor masked unc untouched", uncStatus, 0);
    chk("R7 adv cor masked cor set", corStatus, 32'h2000);
    doReset();
    sendEvt(32'h0004_0000, 0, 1, 0, 16'h0043);
    chk("R7 fatal ignores adv", 32'(gotSev), 3);
    chk("R7 fatal no adv bit", corStatus, 0);
  endtask

  task automatic testOverflow();
    doReset();
    logOverflow = 1;
    sendEvt(32'h0004_0000, 0, 0, 0, 16'h5A5A);
    chk("R9 first msg", 32'(gotMsg), 1);
    chk("R11 ready low on logReq", 32'(gotReady), 0);
    @(negedge clk);
    logOverflow = 0;
    chk("R11 ready low follow-up", 32'(evtReady), 0);
    chk("R9 gap cycle", 32'(msgValid), 0);
    @(negedge clk);
    chk("R9 follow msg", 32'(msgValid), 1);
    chk("R9 follow sev", 32'(msgSeverity), 1);
    chk("R9 follow src", 32'(msgSourceId), 32'h5A5A);
    chk("R9 ovf bit", corStatus, 32'h8000);
    chk("R11 ready back", 32'(evtReady), 1);
    doReset();
    logOverflow = 1; serrEn = 0; ferEn = 0;
    sendEvt(32'h0004_0000, 0, 0, 0, 16'h0050);
    chk("R9 no msg case logReq", 32'(gotLog), 1);
    repeat (2) @(negedge clk);
    logOverflow = 0;
    chk("R9 no follow without msg", corStatus, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    testReset();
    testReject();
    testCorrectable();
    testUncorrectable();
    testUnsupported();
    testAdvisory();
    testOverflow();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule